// File: doc/BRIEF.md
# Fixed-Upper-Bank Program ROM Mapper

This block sits on the cartridge side of an 8-bit console. The CPU sees a 32 KiB program ROM window at $8000-$FFFF. The window is split into two 16 KiB halves. The lower half ($8000-$BFFF) shows whichever ROM bank the CPU last selected. The upper half ($C000-$FFFF) always shows the highest-numbered bank. Because of this, the reset vector and any code that switches banks never move, even though the bank register holds no defined value at power-up.

Software selects a bank by writing to any address in the ROM region. The block does not decode the address any further. The low data bits are latched into the bank register on the clock edge of that write. From then on, the block builds the upper ROM address lines from the bank register or from all ones, and it drives an active-low ROM chip enable for CPU reads of the window. On the video side the pattern memory is a writable 8 KiB RAM. The block passes that RAM's select through from video address bit 13.

Top module: `fixbank_mapper`

## Requirements
- R1: For a CPU access to $8000-$BFFF, `romAddr` equals the bank register in bits [ROM_AW-1:14] and CPU address bits [13:0] in bits [13:0].
- R2: For a CPU access to $C000-$FFFF, `romAddr` bits [ROM_AW-1:14] are all ones, whatever the bank register holds. Bits [13:0] follow the CPU address.
- R3: A CPU write (`cpuStrobe`=1, `cpuRw`=0) at any address with bit 15 set loads `cpuData[BANK_BITS-1:0]` into the bank register on that clock edge. Data bits at and above BANK_BITS are ignored.
- R4: A new bank is visible on the very next bus cycle after the write edge. There are no wait states.
- R5: A write below $8000, or any write while `rstN` is low, leaves the bank register unchanged.
- R6: `romCeN` is low only when `cpuStrobe`=1, `cpuRw`=1 and address bit 15 is 1. It is high in every other case, including writes to the ROM region.
- R7: A read of $FFFC yields ROM address {all ones, 14'h3FFC} regardless of the bank register contents, including right after reset.
- R8: `chrRamSelN` is low when `vidA13` is 0 (video addresses $0000-$1FFF) and high when `vidA13` is 1.
- R9: CPU reads never change the bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the bank register loads on its rising edge |
| rstN | input | 1 | Active-low reset; blocks bank loads while low |
| cpuStrobe | input | 1 | CPU bus cycle valid |
| cpuRw | input | 1 | 1 = read, 0 = write |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | DATA_W (8) | CPU data bus |
| vidA13 | input | 1 | Video address bit 13 |
| romAddr | output | 14+BANK_BITS (18) | Program ROM address |
| romCeN | output | 1 | Program ROM chip enable, active low |
| chrRamSelN | output | 1 | Pattern RAM select, active low |

## Verification
The stimulus writes bank numbers at addresses spread across both halves of the window. It then reads at the lower edge, the upper edge and the middle of each half. This separates a correctly forced upper half from one that follows the register, and a lower half that tracks the register from one that does not. Writes carry data with high bits set, which shows whether only the low bits are taken. Writes below $8000 and writes during reset are each followed by a lower-half read, which shows whether those writes were ignored. Reads placed back-to-back with writes show whether the new bank is visible with no wait states. Idle cycles, write cycles and low-address reads show that the chip enable is gated by both the strobe and the direction.

// File: rtl/fixbank_pkg.sv
package fixbank_pkg;
  // CPU side address width and window geometry
  localparam int CPU_AW   = 16;
  localparam int HALF_AW  = 14;   // 16 KiB half-window offset bits

  // strobes from control to datapath
  typedef struct packed {
    logic loadBank;   // capture bank number this edge
    logic romRead;    // CPU read inside the ROM window
    logic upperHalf;  // access falls in the fixed half
  } fixbank_ctl_t;
endpackage

// File: rtl/fixbank_ctrl.sv
module fixbank_ctrl
  import fixbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuStrobe,
  input  logic              cpuRw,
  input  logic [CPU_AW-1:0] cpuAddr,
  output fixbank_ctl_t      ctl
);
  logic inWindow;
  logic isWrite;
  logic isRead;

  always_comb begin
    inWindow = cpuAddr[CPU_AW-1];
    isWrite  = cpuStrobe && !cpuRw;
    isRead   = cpuStrobe && cpuRw;
  end

  always_comb begin
    ctl           = '0;
    ctl.loadBank  = rstN && isWrite && inWindow;
    ctl.romRead   = isRead && inWindow;
    ctl.upperHalf = cpuAddr[CPU_AW-2];
  end

  // a load never comes from a read cycle
  AST_LOAD_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadBank |-> (!cpuRw && cpuAddr[CPU_AW-1])); // R3
  // read enable and load are mutually exclusive
  AST_READ_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadBank, ctl.romRead})); // R9
endmodule

// File: rtl/fixbank_dp.sv
module fixbank_dp
  import fixbank_pkg::*;
#(
  parameter int BANK_BITS = 4,
  parameter int DATA_W    = 8,
  localparam int ROM_AW   = HALF_AW + BANK_BITS
)(
  input  logic              clk,
  input  logic              rstN,
  input  fixbank_ctl_t      ctl,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  output logic [ROM_AW-1:0] romAddr
);
  // bank register: no reset, content undefined at power-up
  logic [BANK_BITS-1:0] bankQ;

  always_ff @(posedge clk) begin
    if (ctl.loadBank) bankQ <= cpuData[BANK_BITS-1:0];
  end

  // per-bit select between register and forced one
  logic [BANK_BITS-1:0] upperBits;
  for (genvar b = 0; b < BANK_BITS; b++) begin : g_upper
    assign upperBits[b] = ctl.upperHalf | bankQ[b];
  end

  always_comb begin
    romAddr = {upperBits, cpuAddr[HALF_AW-1:0]};
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadBank |=> (bankQ == $past(cpuData[BANK_BITS-1:0]))); // R3
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadBank |=> $stable(bankQ)); // R5
  AST_FIXED_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[CPU_AW-1:CPU_AW-2] == 2'b11) |-> (&romAddr[ROM_AW-1:HALF_AW])); // R2
endmodule

// File: rtl/fixbank_mapper.sv
module fixbank_mapper
  import fixbank_pkg::*;
#(
  parameter int BANK_BITS = 4,
  parameter int DATA_W    = 8,
  localparam int ROM_AW   = HALF_AW + BANK_BITS
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuStrobe,
  input  logic              cpuRw,
  input  logic [15:0]       cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  input  logic              vidA13,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romCeN,
  output logic              chrRamSelN
);
  fixbank_ctl_t ctl;

  fixbank_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cpuStrobe(cpuStrobe),
    .cpuRw    (cpuRw),
    .cpuAddr  (cpuAddr),
    .ctl      (ctl)
  );

  fixbank_dp #(.BANK_BITS(BANK_BITS), .DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .cpuAddr(cpuAddr),
    .cpuData(cpuData),
    .romAddr(romAddr)
  );

  assign romCeN     = !ctl.romRead;
  assign chrRamSelN = vidA13;

  AST_CE_NOT_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStrobe && !cpuRw) |-> romCeN); // R6
  AST_CE_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    !romCeN |-> (cpuStrobe && cpuAddr[15])); // R6
endmodule

// File: tb/fixbank_mapper_tb_top.sv
module fixbank_mapper_tb_top;
  localparam int BANK_BITS = 4;
  localparam int ROM_AW    = 14 + BANK_BITS;

  logic clk = 0;
  logic rstN = 0;
  logic cpuStrobe = 0;
  logic cpuRw = 1;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic vidA13 = 0;
  logic [ROM_AW-1:0] romAddr;
  logic romCeN;
  logic chrRamSelN;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  fixbank_mapper #(.BANK_BITS(BANK_BITS), .DATA_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .cpuStrobe(cpuStrobe), .cpuRw(cpuRw),
    .cpuAddr(cpuAddr), .cpuData(cpuData), .vidA13(vidA13),
    .romAddr(romAddr), .romCeN(romCeN), .chrRamSelN(chrRamSelN)
  );

  typedef struct {
    bit                chkAddr;
    logic [ROM_AW-1:0] expAddr;
    logic              expCe;
    logic              expSel;
    string             req;
  } item_t;

  item_t sbq[$];
  event  drvEv;

  // monitor: pops one expected item per driven cycle, samples mid-low phase
  always begin
    @(drvEv);
    #4;
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      if (it.chkAddr) begin
        checks++;
        if (romAddr !== it.expAddr) begin
          fails++;
          $display("FAIL %s romAddr actual=%h expected=%h", it.req, romAddr, it.expAddr);
        end
      end
      checks++;
      if (romCeN !== it.expCe) begin
        fails++;
        $display("FAIL %s romCeN actual=%b expected=%b", it.req, romCeN, it.expCe);
      end
      checks++;
      if (chrRamSelN !== it.expSel) begin
        fails++;
        $display("FAIL %s chrRamSelN actual=%b expected=%b", it.req, chrRamSelN, it.expSel);
      end
    end
  end

  function automatic logic [ROM_AW-1:0] romOf(input logic [15:0] a, input logic [3:0] bank);
    logic [3:0] hi;
    hi = a[14] ? 4'hF : bank;
    return {hi, a[13:0]};
  endfunction

  // drive one bus cycle at the falling edge and queue its expectation
  task automatic cyc(input bit stb, input bit rw, input logic [15:0] a,
                     input logic [7:0] d, input bit v13, input bit chkA,
                     input logic [ROM_AW-1:0] ea, input string req);
    item_t it;
    @(negedge clk);
    cpuStrobe = stb; cpuRw = rw; cpuAddr = a; cpuData = d; vidA13 = v13;
    it.chkAddr = chkA;
    it.expAddr = ea;
    it.expCe   = !(stb && rw && a[15]);
    it.expSel  = v13;
    it.req     = req;
    sbq.push_back(it);
    ->drvEv;
  endtask

  task automatic rd(input logic [15:0] a, input logic [3:0] bank, input string req);
    cyc(1, 1, a, 8'h00, 0, 1, romOf(a, bank), req);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
    cyc(1, 0, a, d, 0, 0, '0, req);
  endtask

  initial begin
    // reset state: idle bus, no chip enable, select follows video A13 (R6, R8)
    cyc(0, 1, 16'hFFFC, 8'h00, 0, 0, '0, "R6 idle in reset");
    cyc(0, 1, 16'h8000, 8'h00, 1, 0, '0, "R8 vidA13 high");
    repeat (2) @(negedge clk);
    rstN = 1;
    // R7: reset vector from last bank before any bank write
    rd(16'hFFFC, 4'h0, "R7 reset vector");
    rd(16'hFFFD, 4'h0, "R7 reset vector hi");
    // R3/R4: write bank 9, read immediately
    wr(16'h8000, 8'h09, "R3 write bank 9");
    rd(16'h8ABC, 4'h9, "R1 R4 lower half bank 9");
    rd(16'hBFFF, 4'h9, "R1 lower top edge");
    rd(16'hC000, 4'h9, "R2 fixed bottom edge");
    // R5: write during reset ignored
    @(negedge clk); rstN = 0;
    wr(16'h8000, 8'h02, "R5 write in reset");
    @(negedge clk); cpuStrobe = 0; rstN = 1;
    rd(16'h8ABC, 4'h9, "R5 bank kept over reset write");
    // R3: write into upper half with high data bits set
    wr(16'hC123, 8'hF3, "R3 write upper addr");
    rd(16'h8000, 4'h3, "R3 R4 low bits only");
    rd(16'hFFFF, 4'h3, "R2 fixed top edge");
    // R5: write below window ignored
    wr(16'h7FFF, 8'h06, "R5 low write");
    rd(16'hBFFF, 4'h3, "R5 bank unchanged");
    // R6: low read, write cycle and idle strobe give no enable
    cyc(1, 1, 16'h4000, 8'h00, 0, 0, '0, "R6 read below window");
    cyc(0, 1, 16'h9000, 8'h00, 0, 0, '0, "R6 no strobe");
    wr(16'hA000, 8'h00, "R6 write no enable");
    rd(16'h8001, 4'h0, "R1 R4 bank 0");
    rd(16'hFFFC, 4'h0, "R7 vector with bank 0");
    wr(16'hFFFF, 8'h0E, "R3 write at top");
    rd(16'h9234, 4'hE, "R1 bank E");
    // R9: reads leave the bank alone
    rd(16'h8000, 4'hE, "R9 read 1");
    rd(16'hC000, 4'hE, "R9 read 2");
    rd(16'hA5A5, 4'hE, "R9 bank after reads");
    // R8 with active read
    cyc(1, 1, 16'h8002, 8'h00, 1, 1, romOf(16'h8002, 4'hE), "R8 select high in read");
    cyc(0, 1, 16'h0000, 8'h00, 0, 0, '0, "R8 select low");
    @(negedge clk); @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule